// File: doc/BRIEF.md
# Multiplexed-Address DRAM Access Controller

This block sits between a host and a 64K x 4 dynamic memory that has only eight address pins. The host hands over a 16-bit location, a direction flag and, for a store, four data bits. It holds its request until a one-cycle acknowledge comes back, and a load returns its data with that acknowledge. The controller splits the location into two halves on the shared pin bus. The low half (bits 7..0) selects the row and is taken by the memory when the row strobe falls. The high half (bits 15..8) selects the column and is taken when the column strobe falls. The level of the row strobe picks which half is on the pins.

Every access runs a fixed sequence of phases: address setup, row strobe low, column switch, column strobe low, then precharge. Each phase lasts a number of clock cycles set by a parameter. A free-running timer raises a refresh request once per interval. The controller serves each request with a row-only cycle, in which the column strobe stays high. These cycles walk an internal 8-bit row counter through all 256 rows. A waiting refresh wins over a waiting host request, but it never breaks into a cycle that has already started.

Top module: `dram_mux_ctrl`

## Requirements
- R1: While reset is applied, every strobe (`dram_ras_n`, `dram_cas_n`, `dram_we_n`, `dram_oe_n`) is high, `req_ack` is 0 and `dram_dq_oe` is 0.
- R2: In the cycle just before the row strobe falls, the pins carry the access's address bits 7..0, or the refresh row number for a refresh cycle.
- R3: While the row strobe is low, and in particular when the column strobe falls, the pins carry address bits 15..8.
- R4: For a host access, the row strobe stays low for T_RAS+T_COL+T_CAS cycles and the column strobe stays low for T_CAS cycles. Both strobes return high on the same clock edge, and the column strobe is never low while the row strobe is high.
- R5: Between the row strobe rising and its next fall, it stays high for at least T_PRE+T_ROW cycles.
- R6: For a store, `dram_we_n` is already low in the cycle before the column strobe falls and stays low while it is low. `dram_dq_oe` is 1 only while the column strobe is low, and `dram_dq_out` then carries the host's data.
- R7: For a load, `dram_oe_n` is low only while the column strobe is low. The value on `dram_dq_in` in the last column-low cycle appears on `rsp_rdata` together with `req_ack`.
- R8: `dram_oe_n` and `dram_we_n` are never both low.
- R9: Refresh cycles keep the column strobe high and present rows 0, 1, 2, ... in order, wrapping after 255. With no host traffic, one starts every REFRESH_TICKS cycles.
- R10: A waiting refresh is started before a waiting host request. Under continuous host traffic the spacing between refresh cycles stays within REFRESH_TICKS plus the length of one access, and no refresh request is lost.
- R11: Each host request gets exactly one `req_ack`, one cycle wide, on the edge where the strobes return high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request, held until acknowledged |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 16 | Host location; bits 7..0 row, 15..8 column |
| req_wdata | input | 4 | Store data |
| req_ack | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 4 | Load data, valid with `req_ack` |
| dram_addr | output | 8 | Shared row/column address pins |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe and chip select, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_in | input | 4 | Data from the memory |
| dram_dq_out | output | 4 | Data to the memory |
| dram_dq_oe | output | 1 | Drive enable for `dram_dq_out` |

## Verification
The bench places a memory model on the pins. The model takes the row from the pins in the cycle before the row strobe falls and the column at the column strobe fall. A controller that switched the multiplexer at the wrong time would therefore store or fetch the wrong cell, and a load-back would disagree with the expected value. Addresses 0x0000, 0xFFFF and mixed halves such as 0x12AB and 0xAB12 expose a swapped or misaligned half. A long run of back-to-back requests leaves the controller no idle cycle, so a host-first arbiter would starve refresh and show up as an over-long refresh gap. Idle stretches check the exact refresh interval and the row counter order. A sequencer that asserted the column strobe during refresh, or let it rise apart from the row strobe, would break the strobe-width checks.

// File: rtl/dram_mux_pkg.sv
package dram_mux_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROW,
    ST_RAS,
    ST_COL,
    ST_CAS,
    ST_PRE
  } seq_state_e;
endpackage

// File: rtl/dmx_refresh.sv
module dmx_refresh #(
  parameter int REFRESH_TICKS = 64,
  parameter int ROW_W         = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             grant,
  output logic             pend,
  output logic [ROW_W-1:0] row
);
  localparam int TW = $clog2(REFRESH_TICKS + 1);

  logic [TW-1:0]    tmr_q, tmr_d;
  logic             pend_q, pend_d;
  logic [ROW_W-1:0] row_q, row_d;
  logic             tick;

  assign tick = (tmr_q == '0);

  always_comb begin
    tmr_d  = tick ? TW'(REFRESH_TICKS - 1) : tmr_q - 1'b1;
    pend_d = tick | (pend_q & ~grant);
    row_d  = grant ? row_q + 1'b1 : row_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q  <= TW'(REFRESH_TICKS - 1);
      pend_q <= 1'b0;
      row_q  <= '0;
    end else begin
      tmr_q  <= tmr_d;
      pend_q <= pend_d;
      if (grant) row_q <= row_d;
    end
  end

  assign pend = pend_q;
  assign row  = row_q;

  // a new tick must never find the previous request still unserved
  p_no_lost_refresh_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> !pend_q);
  // the row counter only moves when a refresh is granted
  p_row_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !grant |=> $stable(row_q));
endmodule

// File: rtl/dmx_addr_mux.sv
module dmx_addr_mux #(
  parameter int ROW_W = 8
) (
  input  logic [2*ROW_W-1:0] full_addr,
  input  logic               ras_n,
  output logic [ROW_W-1:0]   pins
);
  genvar b;
  generate
    for (b = 0; b < ROW_W; b++) begin : g_bit
      assign pins[b] = ras_n ? full_addr[b] : full_addr[ROW_W + b];
    end
  endgenerate
endmodule

// File: rtl/dmx_seq.sv
module dmx_seq
  import dram_mux_pkg::*;
#(
  parameter int T_ROW  = 1,
  parameter int T_RAS  = 1,
  parameter int T_COL  = 1,
  parameter int T_CAS  = 2,
  parameter int T_PRE  = 2,
  parameter int ROW_W  = 8,
  parameter int DATA_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rfsh_pend,
  input  logic [ROW_W-1:0]    rfsh_row,
  output logic                rfsh_grant,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [2*ROW_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  output logic                ack,
  output logic [DATA_W-1:0]   rdata,
  output logic [2*ROW_W-1:0]  addr_q,
  input  logic [DATA_W-1:0]   dq_in,
  output logic [DATA_W-1:0]   dq_out,
  output logic                dq_oe,
  output logic                ras_n,
  output logic                cas_n,
  output logic                we_n,
  output logic                oe_n
);
  localparam int PH_W = $clog2(T_ROW + T_RAS + T_COL + T_CAS + T_PRE + 1);

  seq_state_e         st_q, st_d;
  logic [PH_W-1:0]    ph_q, ph_d;
  logic               ld_en, rf_sel;
  logic               rf_q, wr_q;
  logic [DATA_W-1:0]  wdata_q;
  logic [2*ROW_W-1:0] a_q;
  logic               ack_q, ack_d;
  logic               rd_en;
  logic [DATA_W-1:0]  rdata_q;
  logic               host_rd, host_wr;

  always_comb begin
    st_d   = st_q;
    ph_d   = ph_q;
    ld_en  = 1'b0;
    rf_sel = 1'b0;
    ack_d  = 1'b0;
    rd_en  = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (rfsh_pend) begin
          ld_en  = 1'b1;
          rf_sel = 1'b1;
          st_d   = ST_ROW;
          ph_d   = PH_W'(T_ROW - 1);
        end else if (req_valid) begin
          ld_en = 1'b1;
          st_d  = ST_ROW;
          ph_d  = PH_W'(T_ROW - 1);
        end
      end
      ST_ROW: begin
        if (ph_q == '0) begin
          st_d = ST_RAS;
          ph_d = PH_W'(T_RAS - 1);
        end else ph_d = ph_q - 1'b1;
      end
      ST_RAS: begin
        if (ph_q == '0) begin
          st_d = ST_COL;
          ph_d = PH_W'(T_COL - 1);
        end else ph_d = ph_q - 1'b1;
      end
      ST_COL: begin
        if (ph_q == '0) begin
          st_d = ST_CAS;
          ph_d = PH_W'(T_CAS - 1);
        end else ph_d = ph_q - 1'b1;
      end
      ST_CAS: begin
        if (ph_q == '0) begin
          st_d  = ST_PRE;
          ph_d  = PH_W'(T_PRE - 1);
          ack_d = ~rf_q;
          rd_en = ~rf_q & ~wr_q;
        end else ph_d = ph_q - 1'b1;
      end
      ST_PRE: begin
        if (ph_q == '0) st_d = ST_IDLE;
        else ph_d = ph_q - 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      ph_q    <= '0;
      rf_q    <= 1'b0;
      wr_q    <= 1'b0;
      wdata_q <= '0;
      a_q     <= '0;
      ack_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      st_q  <= st_d;
      ph_q  <= ph_d;
      ack_q <= ack_d;
      if (ld_en) begin
        rf_q    <= rf_sel;
        wr_q    <= rf_sel ? 1'b0 : req_write;
        wdata_q <= req_wdata;
        a_q     <= rf_sel ? {{ROW_W{1'b0}}, rfsh_row} : req_addr;
      end
      if (rd_en) rdata_q <= dq_in;
    end
  end

  assign host_wr    = wr_q & ~rf_q;
  assign host_rd    = ~wr_q & ~rf_q;
  assign rfsh_grant = ld_en & rf_sel;
  assign ras_n      = ~((st_q == ST_RAS) | (st_q == ST_COL) | (st_q == ST_CAS));
  assign cas_n      = ~((st_q == ST_CAS) & ~rf_q);
  assign we_n       = ~(((st_q == ST_COL) | (st_q == ST_CAS)) & host_wr);
  assign oe_n       = ~((st_q == ST_CAS) & host_rd);
  assign dq_oe      = (st_q == ST_CAS) & host_wr;
  assign dq_out     = wdata_q;
  assign addr_q     = a_q;
  assign ack        = ack_q;
  assign rdata      = rdata_q;

  p_oe_we_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(!oe_n && !we_n));
  p_cas_inside_ras_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n |-> !ras_n);
  p_strobes_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cas_n) |-> $rose(ras_n));
  p_drive_in_cas_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> (!cas_n && !we_n));
  p_ack_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |=> !ack_q);
  p_ack_at_rise_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |-> $rose(ras_n));
endmodule

// File: rtl/dram_mux_ctrl.sv
module dram_mux_ctrl #(
  parameter int T_ROW         = 1,
  parameter int T_RAS         = 1,
  parameter int T_COL         = 1,
  parameter int T_CAS         = 2,
  parameter int T_PRE         = 2,
  parameter int REFRESH_TICKS = 64,
  parameter int ROW_W         = 8,
  parameter int DATA_W        = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [2*ROW_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  output logic                req_ack,
  output logic [DATA_W-1:0]   rsp_rdata,
  output logic [ROW_W-1:0]    dram_addr,
  output logic                dram_ras_n,
  output logic                dram_cas_n,
  output logic                dram_we_n,
  output logic                dram_oe_n,
  input  logic [DATA_W-1:0]   dram_dq_in,
  output logic [DATA_W-1:0]   dram_dq_out,
  output logic                dram_dq_oe
);
  logic               rst_s1_q, rst_s2_q;
  logic               rfsh_pend, rfsh_grant;
  logic [ROW_W-1:0]   rfsh_row;
  logic [2*ROW_W-1:0] addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end

  dmx_refresh #(.REFRESH_TICKS(REFRESH_TICKS), .ROW_W(ROW_W)) u_rfsh (
    .clk   (clk),
    .rst_n (rst_s2_q),
    .grant (rfsh_grant),
    .pend  (rfsh_pend),
    .row   (rfsh_row)
  );

  dmx_seq #(
    .T_ROW(T_ROW), .T_RAS(T_RAS), .T_COL(T_COL), .T_CAS(T_CAS), .T_PRE(T_PRE),
    .ROW_W(ROW_W), .DATA_W(DATA_W)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_s2_q),
    .rfsh_pend  (rfsh_pend),
    .rfsh_row   (rfsh_row),
    .rfsh_grant (rfsh_grant),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .ack        (req_ack),
    .rdata      (rsp_rdata),
    .addr_q     (addr_q),
    .dq_in      (dram_dq_in),
    .dq_out     (dram_dq_out),
    .dq_oe      (dram_dq_oe),
    .ras_n      (dram_ras_n),
    .cas_n      (dram_cas_n),
    .we_n       (dram_we_n),
    .oe_n       (dram_oe_n)
  );

  dmx_addr_mux #(.ROW_W(ROW_W)) u_mux (
    .full_addr (addr_q),
    .ras_n     (dram_ras_n),
    .pins      (dram_addr)
  );

  p_row_before_fall_r2: assert property (@(posedge clk) disable iff (!rst_s2_q)
    $fell(dram_ras_n) |-> $past(dram_addr) == $past(addr_q[ROW_W-1:0]));
  p_col_at_cas_r3: assert property (@(posedge clk) disable iff (!rst_s2_q)
    $fell(dram_cas_n) |-> dram_addr == addr_q[2*ROW_W-1:ROW_W]);
endmodule

// File: tb/dram_mux_ctrl_tb_top.sv
module dram_mux_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int T_ROW = 1, T_RAS = 1, T_COL = 1, T_CAS = 2, T_PRE = 2;
  localparam int TICKS = 64;

  typedef struct {
    bit         wr;
    logic [15:0] addr;
    logic [3:0]  data;
  } op_t;

  logic        clk, rst_n;
  logic        req_valid, req_write;
  logic [15:0] req_addr;
  logic [3:0]  req_wdata;
  logic        req_ack;
  logic [3:0]  rsp_rdata;
  logic [7:0]  dram_addr;
  logic        dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n;
  logic [3:0]  dram_dq_in, dram_dq_out;
  logic        dram_dq_oe;

  int total, bad, cyc, acks, nops, nrf;
  op_t sb_q[$];
  op_t cur;
  logic [3:0] shadow[int];
  logic [3:0] mem[int];
  logic [3:0] rd_val;
  logic [7:0] row_lat, col_lat, exp_rrow;
  logic p_ras, p_cas, p_we;
  logic [7:0] p_addr;
  int ras_cnt, cas_cnt, hi_cnt, last_rf;
  bit cas_seen, host_between, done;

  dram_mux_ctrl #(
    .T_ROW(T_ROW), .T_RAS(T_RAS), .T_COL(T_COL), .T_CAS(T_CAS), .T_PRE(T_PRE),
    .REFRESH_TICKS(TICKS), .ROW_W(8), .DATA_W(4)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ack(req_ack),
    .rsp_rdata(rsp_rdata), .dram_addr(dram_addr), .dram_ras_n(dram_ras_n),
    .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n),
    .dram_dq_in(dram_dq_in), .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [3:0] def_val(logic [15:0] a);
    return a[3:0] ^ a[15:12] ^ 4'h5;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // memory model on the pins
  assign dram_dq_in = (!dram_oe_n && !dram_cas_n) ? rd_val : 4'h0;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      finish_run();
    end
  end

  // monitor and scoreboard
  always @(negedge clk) begin
    if (!rst_n) begin
      p_ras = 1; p_cas = 1; p_we = 1; p_addr = '0;
      hi_cnt = 100; ras_cnt = 0; cas_cnt = 0; last_rf = -1;
      cas_seen = 0; host_between = 0; exp_rrow = '0;
    end else begin
      if (p_ras && !dram_ras_n) begin
        row_lat = p_addr;
        chk(hi_cnt >= T_PRE + T_ROW, "R5 precharge width", hi_cnt, T_PRE + T_ROW);
        ras_cnt = 0;
        cas_seen = 0;
      end
      if (!dram_ras_n) ras_cnt++;
      if (p_cas && !dram_cas_n) begin
        col_lat = dram_addr;
        cas_seen = 1;
        cas_cnt = 0;
        host_between = 1;
        chk(!dram_ras_n, "R4 cas inside ras", dram_ras_n, 0);
        if (sb_q.size() == 0) begin
          chk(0, "R10 access without request", 1, 0);
        end else begin
          cur = sb_q.pop_front();
          chk(row_lat == cur.addr[7:0], "R2 row half", row_lat, cur.addr[7:0]);
          chk(dram_addr == cur.addr[15:8], "R3 column half", dram_addr, cur.addr[15:8]);
          if (cur.wr) begin
            chk(p_we == 1'b0, "R6 we before cas", p_we, 0);
            chk(dram_dq_oe && dram_dq_out == cur.data, "R6 write data",
                dram_dq_out, cur.data);
            mem[{col_lat, row_lat}] = dram_dq_out;
          end else begin
            chk(dram_we_n, "R6 no we on load", dram_we_n, 1);
            rd_val = mem.exists({col_lat, row_lat}) ? mem[{col_lat, row_lat}]
                                                     : def_val({col_lat, row_lat});
          end
        end
      end
      if (!dram_cas_n) begin
        cas_cnt++;
        chk(dram_addr == col_lat, "R3 column held", dram_addr, col_lat);
        if (cur.wr) chk(!dram_we_n, "R6 we held", dram_we_n, 0);
      end
      if (!p_cas && dram_cas_n) begin
        chk(cas_cnt == T_CAS, "R4 cas width", cas_cnt, T_CAS);
        chk(!p_ras && dram_ras_n, "R4 strobes rise together", dram_ras_n, 1);
      end
      if (!p_ras && dram_ras_n) begin
        hi_cnt = 0;
        if (cas_seen) begin
          chk(ras_cnt == T_RAS + T_COL + T_CAS, "R4 ras width", ras_cnt,
              T_RAS + T_COL + T_CAS);
        end else begin
          nrf++;
          chk(row_lat == exp_rrow, "R9 refresh row order", row_lat, exp_rrow);
          exp_rrow = exp_rrow + 1'b1;
          if (last_rf >= 0) begin
            if (!host_between)
              chk(cyc - last_rf == TICKS, "R9 idle refresh interval", cyc - last_rf, TICKS);
            chk(cyc - last_rf <= TICKS + 20, "R10 refresh gap under traffic",
                cyc - last_rf, TICKS + 20);
          end
          last_rf = cyc;
          host_between = 0;
        end
      end else if (dram_ras_n) begin
        hi_cnt++;
      end
      if (!dram_oe_n && !dram_we_n) chk(0, "R8 oe and we both low", 0, 1);
      if (!dram_oe_n) chk(!dram_cas_n, "R7 oe only with cas", dram_cas_n, 0);
      if (dram_dq_oe) chk(!dram_cas_n, "R6 drive only with cas", dram_cas_n, 0);
      if (req_ack) begin
        acks++;
        chk(!p_ras && dram_ras_n, "R11 ack at strobe rise", dram_ras_n, 1);
        if (!cur.wr) chk(rsp_rdata == cur.data, "R7 load data", rsp_rdata, cur.data);
      end
      p_ras = dram_ras_n; p_cas = dram_cas_n; p_we = dram_we_n; p_addr = dram_addr;
    end
  end

  task automatic do_op(bit wr, logic [15:0] a, logic [3:0] d);
    op_t o;
    int n;
    o.wr = wr;
    o.addr = a;
    if (wr) begin
      shadow[a] = d;
      o.data = d;
    end else begin
      o.data = shadow.exists(a) ? shadow[a] : def_val(a);
    end
    sb_q.push_back(o);
    nops++;
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = a;
    req_wdata = d;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!req_ack && n < 500);
    if (n >= 500) chk(0, "R11 ack missing", 0, 1);
    else if (req_ack) begin
      @(posedge clk);
      #1;
      chk(!req_ack, "R11 ack one cycle", req_ack, 0);
      req_valid = 1'b0;
      @(negedge clk);
    end
    req_valid = 1'b0;
  endtask

  initial begin
    logic [15:0] lfsr;
    total = 0; bad = 0; cyc = 0; acks = 0; nops = 0; nrf = 0; done = 0;
    rd_val = 4'h0; row_lat = '0; col_lat = '0;
    cur.wr = 0; cur.addr = '0; cur.data = '0;
    rst_n = 1'b0;
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(dram_ras_n && dram_cas_n, "R1 strobes high in reset", {dram_ras_n, dram_cas_n}, 3);
    chk(dram_we_n && dram_oe_n, "R1 we/oe high in reset", {dram_we_n, dram_oe_n}, 3);
    chk(!req_ack && !dram_dq_oe, "R1 ack and drive low", {req_ack, dram_dq_oe}, 0);
    rst_n = 1'b1;
    // idle refresh stretch: R9 interval and row order
    repeat (3 * TICKS + 10) @(negedge clk);
    // stores and loads with boundary addresses: R2 R3 R6 R7
    do_op(1, 16'h0000, 4'h3);
    do_op(1, 16'hFFFF, 4'hC);
    do_op(1, 16'h12AB, 4'h9);
    do_op(1, 16'hAB12, 4'h6);
    do_op(1, 16'h00FF, 4'h1);
    do_op(1, 16'hFF00, 4'hE);
    do_op(0, 16'h0000, 4'h0);
    do_op(0, 16'hFFFF, 4'h0);
    do_op(0, 16'h12AB, 4'h0);
    do_op(0, 16'hAB12, 4'h0);
    do_op(0, 16'h00FF, 4'h0);
    do_op(0, 16'hFF00, 4'h0);
    do_op(0, 16'h5A5A, 4'h0);
    do_op(1, 16'h12AB, 4'h2);
    do_op(0, 16'h12AB, 4'h0);
    // back-to-back traffic: R10 refresh must still win
    lfsr = 16'hACE1;
    for (int i = 0; i < 60; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      do_op(lfsr[0], {lfsr[7:0], lfsr[15:8]} & 16'h0F0F, lfsr[11:8]);
    end
    repeat (2 * TICKS + 10) @(negedge clk);
    chk(sb_q.size() == 0, "R11 all requests served", sb_q.size(), 0);
    chk(acks == nops, "R11 one ack per request", acks, nops);
    chk(nrf >= 10, "R9 refresh cycles seen", nrf, 10);
    done = 1;
    finish_run();
  end
endmodule